// File: doc/BRIEF.md
# Receive Mailbox Bank with Acceptance Filtering and Chaining

The block holds sixteen receive mailboxes for a CAN controller. A bit-level receiver in front of it hands over each complete frame in a single cycle: identifier, extended-format flag, remote-request flag, length code and up to eight payload bytes. Each mailbox compares the frame against its own 32-bit code word under its own 32-bit mask. The block then picks the one mailbox that stores the frame. Software sets up masks, codes and command bits through a small register port. It reads back the stored frames and releases mailboxes once it has read them.

The identifier, the format flag and the remote flag are packed into one comparison word, so one mask/code pair filters all three. A set mask bit makes that bit a don't-care. This lets one mailbox accept a whole range of identifiers. Mailboxes can be chained through a link bit. Successive matching frames then fill the chain in order instead of overwriting one another. A 32-bit status word shows which receive mailboxes hold unread frames and which of eight transmit buffers have pending requests.

Top module: `can_rx_mailbox_bank`

## Requirements
- R1: The comparison word carries IDE at bit 2 and RTR at bit 1, and bit 0 is always 0. A standard frame puts its 11-bit identifier at bits 31:21 and zeros at bits 20:3. A mailbox matches only when it is enabled (command bit 5) and every bit with a mask bit of 0 equals the corresponding code bit.
- R2: An extended frame puts its 29-bit identifier at bits 31:3, and the filter compares all 29 bits.
- R3: A code of 0x180 at bits 31:21, with only the low three identifier mask bits set, accepts standard identifiers 0x180 to 0x187 and rejects 0x17F and 0x188.
- R4: IDE and RTR take part in the filter like identifier bits. A mailbox whose code and mask require IDE=0 rejects extended frames, and one that requires RTR=1 rejects data frames.
- R5: When several unlinked mailboxes match a frame, only the lowest-numbered one stores it.
- R6: Without linking, a new matching frame overwrites the contents of an occupied mailbox.
- R7: Command bit 6 links a mailbox to the next one. Matching frames go to the first mailbox, from the matched one onward along the chain, whose available bit is clear. When the whole chain is full, the last mailbox of the chain is overwritten.
- R8: The link bit of the highest-numbered mailbox always reads 0.
- R9: Command bit 7 is a write protect that resets to 1. A command write changes the link bit only while the stored write-protect bit is 0.
- R10: Status bits 15:0 are the receive available bits, bits 23:16 follow tx_pend_i, and bits 31:24 read 0.
- R11: Register 3 of a mailbox is its control word: the length code at bits 3:0, the stored IDE at bit 20 and the RTR indication at bit 21. Register 4 returns the stored comparison word. Registers 5 and 6 return payload bytes 0 to 3 and 4 to 7, with byte 0 in the low bits.
- R12: Writing a command word with bit 0 set clears that mailbox's available bit, unless a frame is stored into it in the same cycle.
- R13: After reset all available bits are 0, masks and codes are 0, and every command register reads 0x80 (protected, disabled, unlinked).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | One-cycle strobe: a complete frame is presented |
| rx_ide_i | input | 1 | Frame uses the extended identifier |
| rx_rtr_i | input | 1 | Frame is a remote request |
| rx_id_i | input | 29 | Identifier; a standard frame uses bits 10:0 |
| rx_dlc_i | input | 4 | Length code |
| rx_data_i | input | 64 | Payload; byte 0 in bits 7:0 |
| tx_pend_i | input | 8 | Transmit request pending flags |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 7 | Mailbox number in bits 6:3; register in bits 2:0 (0 mask, 1 code, 2 command, 3 control, 4 comparison word, 5 payload low, 6 payload high) |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data of the addressed register |
| status_o | output | 32 | Available and pending status word |

## Verification
A table of frames runs against five overlapping filters. It covers the edges of the identifier range, the frames that differ only in IDE or RTR, and the overlap in which the lower mailbox must win. A design that mixed up the standard and extended layouts, or ignored RTR, would light the wrong status bit. A three-mailbox chain is filled past its end. The test then checks that the tail is overwritten and the head survives, and that a released middle slot is refilled before the tail. Further tests check that the link bit ignores writes while protected and that the last mailbox cannot be linked. A design that let the release win over a store, or kept a stale RTR flag, would show a wrong readback.

// File: rtl/can_mbx_pkg.sv
package can_mbx_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned ID_W      = 29;
  localparam int unsigned STD_W     = 11;
  localparam int unsigned DLC_W     = 4;
  localparam int unsigned PAYLOAD_W = 64;
  localparam int unsigned HALF_W    = PAYLOAD_W / 2;

  // command word bits
  localparam int unsigned CMD_RELEASE = 0;
  localparam int unsigned CMD_EN      = 5;
  localparam int unsigned CMD_LINK    = 6;
  localparam int unsigned CMD_WP      = 7;

  // comparison word bits
  localparam int unsigned FW_RTR = 1;
  localparam int unsigned FW_IDE = 2;

  // control word bits
  localparam int unsigned CTRL_IDE = 20;
  localparam int unsigned CTRL_RTR = 21;

  typedef enum logic [2:0] {
    SEL_MASK = 3'd0,
    SEL_CODE = 3'd1,
    SEL_CMD  = 3'd2,
    SEL_CTRL = 3'd3,
    SEL_WORD = 3'd4,
    SEL_DLO  = 3'd5,
    SEL_DHI  = 3'd6,
    SEL_NONE = 3'd7
  } reg_sel_e;

  function automatic logic [WORD_W-1:0] frame_word(input logic ide, input logic rtr,
                                                   input logic [ID_W-1:0] id);
    logic [WORD_W-1:0] w;
    if (ide) w = {id, 1'b1, rtr, 1'b0};
    else     w = {id[STD_W-1:0], {(ID_W-STD_W){1'b0}}, 1'b0, rtr, 1'b0};
    return w;
  endfunction
endpackage

// File: rtl/can_mbx_filter.sv
module can_mbx_filter
  import can_mbx_pkg::*;
#(
  parameter int unsigned NUM_MBOX = 16
) (
  input  logic [WORD_W-1:0]                word_i,
  input  logic [NUM_MBOX-1:0][WORD_W-1:0]  mask_i,
  input  logic [NUM_MBOX-1:0][WORD_W-1:0]  code_i,
  input  logic [NUM_MBOX-1:0]              en_i,
  output logic [NUM_MBOX-1:0]              match_o
);
  for (genvar g = 0; g < NUM_MBOX; g++) begin : g_cmp
    assign match_o[g] = en_i[g] && (((word_i ^ code_i[g]) & ~mask_i[g]) == '0);
  end
endmodule

// File: rtl/can_mbx_select.sv
module can_mbx_select #(
  parameter int unsigned NUM_MBOX = 16
) (
  input  logic                valid_i,
  input  logic [NUM_MBOX-1:0] match_i,
  input  logic [NUM_MBOX-1:0] avail_i,
  input  logic [NUM_MBOX-1:0] link_i,
  output logic [NUM_MBOX-1:0] store_o
);
  // scan up from the lowest match; follow links past full slots
  always_comb begin
    logic seen;
    logic done;
    store_o = '0;
    seen    = 1'b0;
    done    = 1'b0;
    for (int i = 0; i < NUM_MBOX; i++) begin
      if (!done) begin
        if (match_i[i]) seen = 1'b1;
        if (seen && (!avail_i[i] || !link_i[i])) begin
          store_o[i] = valid_i;
          done       = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/can_mbx_slot.sv
module can_mbx_slot
  import can_mbx_pkg::*;
#(
  parameter bit LINKABLE = 1'b1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  reg_sel_e             wsel_i,
  input  logic [WORD_W-1:0]    wdata_i,
  input  logic                 store_i,
  input  logic [WORD_W-1:0]    word_i,
  input  logic [DLC_W-1:0]     dlc_i,
  input  logic [PAYLOAD_W-1:0] data_i,
  input  reg_sel_e             rsel_i,
  output logic [WORD_W-1:0]    mask_o,
  output logic [WORD_W-1:0]    code_o,
  output logic                 en_o,
  output logic                 link_o,
  output logic                 avail_o,
  output logic [WORD_W-1:0]    rdata_o
);
  logic [WORD_W-1:0]    mask_q, code_q, word_q;
  logic                 en_q, wp_q, link_q, avail_q;
  logic [DLC_W-1:0]     dlc_q;
  logic [PAYLOAD_W-1:0] data_q;
  logic                 cmd_wr, release_req;

  assign cmd_wr      = we_i && (wsel_i == SEL_CMD);
  assign release_req = cmd_wr && wdata_i[CMD_RELEASE];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      code_q <= '0;
      en_q   <= 1'b0;
      wp_q   <= 1'b1;
    end else if (we_i) begin
      if (wsel_i == SEL_MASK) mask_q <= wdata_i;
      if (wsel_i == SEL_CODE) code_q <= wdata_i;
      if (wsel_i == SEL_CMD) begin
        en_q <= wdata_i[CMD_EN];
        wp_q <= wdata_i[CMD_WP];
      end
    end
  end

  if (LINKABLE) begin : g_link
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                link_q <= 1'b0;
      else if (cmd_wr && !wp_q)   link_q <= wdata_i[CMD_LINK];
    end
  end else begin : g_nolink
    assign link_q = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          avail_q <= 1'b0;
    else if (store_i)     avail_q <= 1'b1;
    else if (release_req) avail_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      dlc_q  <= '0;
      data_q <= '0;
    end else if (store_i) begin
      word_q <= word_i;
      dlc_q  <= dlc_i;
      data_q <= data_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (rsel_i)
      SEL_MASK: rdata_o = mask_q;
      SEL_CODE: rdata_o = code_q;
      SEL_CMD: begin
        rdata_o[CMD_EN]   = en_q;
        rdata_o[CMD_LINK] = link_q;
        rdata_o[CMD_WP]   = wp_q;
      end
      SEL_CTRL: begin
        rdata_o[DLC_W-1:0] = dlc_q;
        rdata_o[CTRL_IDE]  = word_q[FW_IDE];
        rdata_o[CTRL_RTR]  = word_q[FW_RTR];
      end
      SEL_WORD: rdata_o = word_q;
      SEL_DLO:  rdata_o = data_q[HALF_W-1:0];
      SEL_DHI:  rdata_o = data_q[PAYLOAD_W-1:HALF_W];
      default:  rdata_o = '0;
    endcase
  end

  assign mask_o  = mask_q;
  assign code_o  = code_q;
  assign en_o    = en_q;
  assign link_o  = link_q;
  assign avail_o = avail_q;

  AST_WP_GUARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && wp_q) |=> $stable(link_q)); // R9
  AST_STORE_AVAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_i |=> avail_q); // R6
  AST_RELEASE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (release_req && !store_i) |=> !avail_q); // R12
  AST_RTR_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (store_i && word_i[FW_RTR]) |=> (rsel_i != SEL_CTRL) || rdata_o[CTRL_RTR]); // R11
endmodule

// File: rtl/can_rx_mailbox_bank.sv
module can_rx_mailbox_bank
  import can_mbx_pkg::*;
#(
  parameter int unsigned NUM_MBOX = 16,
  parameter int unsigned NUM_TX   = 8,
  localparam int unsigned MBOX_W  = $clog2(NUM_MBOX),
  localparam int unsigned ADDR_W  = MBOX_W + 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 rx_valid_i,
  input  logic                 rx_ide_i,
  input  logic                 rx_rtr_i,
  input  logic [ID_W-1:0]      rx_id_i,
  input  logic [DLC_W-1:0]     rx_dlc_i,
  input  logic [PAYLOAD_W-1:0] rx_data_i,
  input  logic [NUM_TX-1:0]    tx_pend_i,
  input  logic                 reg_we_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic [WORD_W-1:0]    reg_wdata_i,
  output logic [WORD_W-1:0]    reg_rdata_o,
  output logic [WORD_W-1:0]    status_o
);
  logic [WORD_W-1:0]               word;
  logic [NUM_MBOX-1:0][WORD_W-1:0] mask, code, slot_rdata;
  logic [NUM_MBOX-1:0]             en, link, avail, match, store_vec;
  logic [MBOX_W-1:0]               sel_mbox;
  reg_sel_e                        sel_reg;

  assign word     = frame_word(rx_ide_i, rx_rtr_i, rx_id_i);
  assign sel_mbox = reg_addr_i[ADDR_W-1:3];
  assign sel_reg  = reg_sel_e'(reg_addr_i[2:0]);

  can_mbx_filter #(.NUM_MBOX(NUM_MBOX)) i_filter (
    .word_i (word),
    .mask_i (mask),
    .code_i (code),
    .en_i   (en),
    .match_o(match)
  );

  can_mbx_select #(.NUM_MBOX(NUM_MBOX)) i_select (
    .valid_i(rx_valid_i),
    .match_i(match),
    .avail_i(avail),
    .link_i (link),
    .store_o(store_vec)
  );

  for (genvar g = 0; g < NUM_MBOX; g++) begin : g_slot
    can_mbx_slot #(.LINKABLE(g != NUM_MBOX - 1)) i_slot (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (reg_we_i && (32'(sel_mbox) == g)),
      .wsel_i (sel_reg),
      .wdata_i(reg_wdata_i),
      .store_i(store_vec[g]),
      .word_i (word),
      .dlc_i  (rx_dlc_i),
      .data_i (rx_data_i),
      .rsel_i (sel_reg),
      .mask_o (mask[g]),
      .code_o (code[g]),
      .en_o   (en[g]),
      .link_o (link[g]),
      .avail_o(avail[g]),
      .rdata_o(slot_rdata[g])
    );
  end

  assign reg_rdata_o = (32'(sel_mbox) < NUM_MBOX) ? slot_rdata[sel_mbox] : '0;
  assign status_o    = WORD_W'(avail) | (WORD_W'(tx_pend_i) << NUM_MBOX);

  AST_ONE_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(store_vec)); // R5
  AST_NO_MATCH_NO_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match == '0) |-> (store_vec == '0)); // R1
  AST_MATCH_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && match != '0) |-> (store_vec != '0)); // R7
  for (genvar g = 1; g < NUM_MBOX; g++) begin : g_chk
    AST_CHAIN_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      store_vec[g] |-> (match[g] || link[g-1])); // R7
  end
endmodule

// File: tb/test_can_rx_mailbox_bank.sv
`timescale 1ns/1ps
module test_can_rx_mailbox_bank;
  import can_mbx_pkg::*;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rx_valid_i = 1'b0, rx_ide_i = 1'b0, rx_rtr_i = 1'b0;
  logic [28:0] rx_id_i = '0;
  logic [3:0]  rx_dlc_i = '0;
  logic [63:0] rx_data_i = '0;
  logic [7:0]  tx_pend_i = '0;
  logic        reg_we_i = 1'b0;
  logic [6:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o, status_o;

  int n_run = 0, n_fail = 0;
  logic [31:0] cmd_sh [16];
  logic [31:0] rd;

  always #2 clk_i = ~clk_i;

  can_rx_mailbox_bank i_can_rx_mailbox_bank (.*);

  // {ide, rtr, id, expected available bits}
  localparam logic [46:0] VEC [11] = '{
    {1'b0, 1'b0, 29'h123,      16'h0001},  // R1 R5
    {1'b0, 1'b0, 29'h180,      16'h0002},  // R3
    {1'b0, 1'b0, 29'h187,      16'h0002},  // R3
    {1'b0, 1'b0, 29'h188,      16'h0010},  // R3
    {1'b0, 1'b0, 29'h17F,      16'h0010},  // R3
    {1'b1, 1'b0, 29'h1ABCDEF1, 16'h0004},  // R2
    {1'b1, 1'b1, 29'h1ABCDEF1, 16'h0004},  // R2
    {1'b1, 1'b0, 29'h1ABCDEF0, 16'h0000},  // R2
    {1'b0, 1'b1, 29'h055,      16'h0008},  // R4
    {1'b1, 1'b0, 29'h123,      16'h0000},  // R4
    {1'b0, 1'b1, 29'h123,      16'h0008}   // R4
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input int mb, input reg_sel_e s, input logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = {4'(mb), 3'(s)}; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic reg_rd(input int mb, input reg_sel_e s, output logic [31:0] d);
    @(negedge clk_i);
    reg_addr_i = {4'(mb), 3'(s)};
    #1 d = reg_rdata_o;
  endtask

  task automatic set_cmd(input int mb, input logic [31:0] v);
    cmd_sh[mb] = v;
    reg_wr(mb, SEL_CMD, v);
  endtask

  task automatic release_box(input int mb);
    reg_wr(mb, SEL_CMD, cmd_sh[mb] | 32'h1);
  endtask

  task automatic send(input logic ide, input logic rtr, input logic [28:0] id,
                      input logic [3:0] dlc, input logic [63:0] d);
    @(negedge clk_i);
    rx_valid_i = 1'b1; rx_ide_i = ide; rx_rtr_i = rtr; rx_id_i = id;
    rx_dlc_i = dlc; rx_data_i = d;
    @(negedge clk_i);
    rx_valid_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) cmd_sh[i] = 32'h80;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R13 reset state
    #1 chk("R13 status", status_o, 32'h0);
    reg_rd(0, SEL_CMD, rd);  chk("R13 cmd", rd, 32'h80);
    reg_rd(9, SEL_MASK, rd); chk("R13 mask", rd, 32'h0);

    // R10 status layout
    tx_pend_i = 8'hA5;
    #1 chk("R10 status", status_o, 32'h00A5_0000);
    tx_pend_i = 8'h00;

    // filters for table
    reg_wr(0, SEL_MASK, {11'h000, 18'h3FFFF, 3'b001}); reg_wr(0, SEL_CODE, {11'h123, 18'h0, 3'b000});
    reg_wr(1, SEL_MASK, {11'h007, 18'h3FFFF, 3'b001}); reg_wr(1, SEL_CODE, {11'h180, 18'h0, 3'b000});
    reg_wr(2, SEL_MASK, {29'h0, 3'b011});              reg_wr(2, SEL_CODE, {29'h1ABCDEF1, 3'b100});
    reg_wr(3, SEL_MASK, {11'h7FF, 18'h3FFFF, 3'b001}); reg_wr(3, SEL_CODE, {11'h000, 18'h0, 3'b010});
    reg_wr(4, SEL_MASK, {11'h7FF, 18'h3FFFF, 3'b011}); reg_wr(4, SEL_CODE, 32'h0);
    for (int i = 0; i < 5; i++) set_cmd(i, 32'hA0);

    for (int v = 0; v < 11; v++) begin
      for (int i = 0; i < 5; i++) release_box(i);
      send(VEC[v][46], VEC[v][45], VEC[v][44:16], 4'd8, 64'h0);
      #1 chk($sformatf("R1-R5 vector %0d", v), {16'h0, status_o[15:0]}, {16'h0, VEC[v][15:0]});
    end
    for (int i = 0; i < 5; i++) release_box(i);

    // R6 overwrite and R11 readback
    send(1'b0, 1'b0, 29'h123, 4'd8, 64'h1111_2222_3333_4444);
    send(1'b0, 1'b0, 29'h123, 4'd8, 64'hAAAA_BBBB_CCCC_DDDD);
    #1 chk("R6 status", status_o, 32'h0001);
    reg_rd(0, SEL_DLO, rd);  chk("R6 data low", rd, 32'hCCCC_DDDD);
    reg_rd(0, SEL_DHI, rd);  chk("R11 data high", rd, 32'hAAAA_BBBB);
    reg_rd(0, SEL_CTRL, rd); chk("R11 ctrl data frame", rd, 32'h0000_0008);
    send(1'b0, 1'b1, 29'h055, 4'd0, 64'h0);
    reg_rd(3, SEL_CTRL, rd); chk("R11 ctrl rtr", rd, 32'h0020_0000);
    reg_rd(3, SEL_WORD, rd); chk("R11 word", rd, {11'h055, 18'h0, 3'b010});

    // R12 release
    release_box(0);
    #1 chk("R12 status", status_o, 32'h0008);
    release_box(3);

    // R9 chain setup under write protect
    for (int i = 5; i < 8; i++) begin
      reg_wr(i, SEL_MASK, {29'h0, 3'b001});
      reg_wr(i, SEL_CODE, {29'h55, 3'b100});
    end
    set_cmd(5, 32'hE0);
    reg_rd(5, SEL_CMD, rd); chk("R9 link blocked", rd, 32'hA0);
    set_cmd(5, 32'h20); set_cmd(5, 32'h60);
    reg_rd(5, SEL_CMD, rd); chk("R9 link set", rd, 32'h60);
    set_cmd(6, 32'h20); set_cmd(6, 32'h60);
    set_cmd(7, 32'h20);

    // R8 last mailbox
    set_cmd(15, 32'h20); set_cmd(15, 32'h60);
    reg_rd(15, SEL_CMD, rd); chk("R8 last link", rd, 32'h20);
    set_cmd(15, 32'h00);

    // R7 chain fill
    send(1'b1, 1'b0, 29'h55, 4'd1, 64'd1);
    #1 chk("R7 first", status_o, 32'h0020);
    send(1'b1, 1'b0, 29'h55, 4'd1, 64'd2);
    #1 chk("R7 second", status_o, 32'h0060);
    send(1'b1, 1'b0, 29'h55, 4'd1, 64'd3);
    #1 chk("R7 third", status_o, 32'h00E0);
    send(1'b1, 1'b0, 29'h55, 4'd1, 64'd4);
    #1 chk("R7 full", status_o, 32'h00E0);
    reg_rd(7, SEL_DLO, rd); chk("R7 tail overwritten", rd, 32'd4);
    reg_rd(5, SEL_DLO, rd); chk("R7 head kept", rd, 32'd1);
    release_box(6);
    send(1'b1, 1'b0, 29'h55, 4'd1, 64'd5);
    reg_rd(6, SEL_DLO, rd); chk("R7 refill middle", rd, 32'd5);
    reg_rd(7, SEL_DLO, rd); chk("R7 tail untouched", rd, 32'd4);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule